// File: doc/BRIEF.md
# Peripheral Access Firewall Filter

This block sits beside the bus fabric that feeds a group of protected peripheral slots and decides, for every access, whether it may proceed. Each access carries a secure bit, a privilege bit and a 3-bit compartment identifier. The block compares these with the configuration held for the target slot and returns an allow/deny decision in the same cycle. Address decode and the bus protocol stay outside; the fabric gives the slot index of the access and blocks it when `acc_allow` is low.

Each slot holds a secure level, a privilege level, a compartment-filter enable, a static owner compartment, a semaphore-mode enable, a bitmap of compartments that may take the slot's semaphore, and a lock bit. A small register port serves configuration. Full writes come only from the domain-owner compartment. A requester that already has access may change only the secure or privilege level, and only within its own rights. Any requester may read. Denied accesses set a sticky per-slot violation bit and raise a one-cycle interrupt pulse.

Top module: `slot_firewall`

## Requirements
- R1: After reset every slot's attribute word is zero, every violation bit is zero and `viol_irq` is low, so an access with any secure, privilege and compartment value is allowed.
- R2: With the filter enable (attribute bit 2) set and semaphore mode (bit 3) clear, only accesses whose compartment equals the slot's static compartment (bits 6:4) are allowed.
- R3: With semaphore mode set, only the compartment currently holding the slot's semaphore is allowed, and only while its bit in the bitmap (bits 15:8, bit 8+c for compartment c) is set. With an all-zero bitmap every access is denied.
- R4: A slot with the secure bit (bit 0) set denies accesses with `acc_sec` low. A slot with the privilege bit (bit 1) set denies accesses with `acc_priv` low.
- R5: A write to the attribute register (`cfg_sel`=0) replaces the whole word only when `cfg_cid` equals the owner compartment (default 1). Reads return the word for any requester.
- R6: While a slot's lock bit (bit 7) is set, no write of any requester changes its attribute word until reset.
- R7: A non-owner requester whose attributes pass the slot's check may change bit 0 when `cfg_sec` is high and bit 1 when `cfg_priv` is high. All other bits are kept.
- R8: A read of the semaphore register (`cfg_sel`=1) returns bit 0 = granted and bit 1 = busy before the read. It takes the semaphore when the slot is in semaphore mode, the semaphore is free and the requester's bitmap bit is set. Only the holder releases it, by writing zero to that register.
- R9: Each denied access sets the violation bit of its slot, which reads back at bit s of `cfg_sel`=2. It also drives `viol_irq` high for exactly the following cycle.
- R10: A write to `cfg_sel`=2 by the owner clears the violation bits set in the write data. A write by any other requester has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_slot | input | 4 | Target slot of the access |
| acc_sec | input | 1 | Access is secure |
| acc_priv | input | 1 | Access is privileged |
| acc_cid | input | 3 | Compartment of the access |
| acc_allow | output | 1 | Access permitted (combinational) |
| cfg_valid | input | 1 | Register port request |
| cfg_write | input | 1 | 1 write, 0 read |
| cfg_slot | input | 4 | Slot addressed |
| cfg_sel | input | 2 | 0 attributes, 1 semaphore, 2 violations |
| cfg_wdata | input | 16 | Write data |
| cfg_sec | input | 1 | Requester is secure |
| cfg_priv | input | 1 | Requester is privileged |
| cfg_cid | input | 3 | Requester compartment |
| cfg_rdata | output | 16 | Read data (combinational) |
| viol_irq | output | 1 | One-cycle pulse after a denied access |

## Verification
Some rules are checked on every cycle. Secure and privilege denial, denial on a compartment mismatch and on an empty semaphore bitmap, the freeze of locked slots, the rule that non-owners cannot touch filter fields, and the link between each denial and the following interrupt pulse with its sticky bit. Directed scenarios cover the rest. These are the semaphore take, refuse and release sequence across several compartments, delegated changes to the secure and privilege levels, readback by foreign compartments, and the selective clear of violation bits.

// File: rtl/slot_firewall.sv
module slot_firewall #(
  parameter int NUM_SLOTS = 16,
  parameter int CID_W     = 3,
  parameter int OWNER_CID = 1,
  localparam int SW     = $clog2(NUM_SLOTS),
  localparam int NCID   = 1 << CID_W,
  localparam int AW     = 5 + CID_W + NCID,
  localparam int DW     = (AW > NUM_SLOTS) ? AW : NUM_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SW-1:0]    acc_slot,
  input  logic             acc_sec,
  input  logic             acc_priv,
  input  logic [CID_W-1:0] acc_cid,
  output logic             acc_allow,
  input  logic             cfg_valid,
  input  logic             cfg_write,
  input  logic [SW-1:0]    cfg_slot,
  input  logic [1:0]       cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             cfg_sec,
  input  logic             cfg_priv,
  input  logic [CID_W-1:0] cfg_cid,
  output logic [DW-1:0]    cfg_rdata,
  output logic             viol_irq
);
  localparam int B_SEC = 0, B_PRIV = 1, B_CFEN = 2, B_SEM = 3;
  localparam int B_CID = 4, B_LOCK = 4 + CID_W, B_MAP = 5 + CID_W;

  logic [NUM_SLOTS-1:0][AW-1:0]    attr_q;
  logic [NUM_SLOTS-1:0]            busy_q;
  logic [NUM_SLOTS-1:0][CID_W-1:0] holder_q;
  logic [NUM_SLOTS-1:0]            viol_q;
  logic                            irq_q;

  function automatic logic permits(input logic [AW-1:0] a, input logic busy,
                                   input logic [CID_W-1:0] hold, input logic sec,
                                   input logic priv, input logic [CID_W-1:0] cid);
    logic cid_ok;
    if (a[B_SEM])       cid_ok = busy && (hold == cid) && a[B_MAP + int'(cid)];
    else if (a[B_CFEN]) cid_ok = (a[B_CID +: CID_W] == cid);
    else                cid_ok = 1'b1;
    return (sec | ~a[B_SEC]) & (priv | ~a[B_PRIV]) & cid_ok;
  endfunction

  logic acc_ok, deny;
  assign acc_ok    = permits(attr_q[acc_slot], busy_q[acc_slot], holder_q[acc_slot],
                             acc_sec, acc_priv, acc_cid);
  assign acc_allow = acc_valid & acc_ok;
  assign deny      = acc_valid & ~acc_ok;
  assign viol_irq  = irq_q;

  logic [AW-1:0] c_attr, new_attr;
  logic is_owner, c_access, wr, rd, sem_grant;
  assign c_attr    = attr_q[cfg_slot];
  assign is_owner  = (cfg_cid == CID_W'(OWNER_CID));
  assign c_access  = permits(c_attr, busy_q[cfg_slot], holder_q[cfg_slot],
                             cfg_sec, cfg_priv, cfg_cid);
  assign wr        = cfg_valid & cfg_write;
  assign rd        = cfg_valid & ~cfg_write;
  assign sem_grant = c_attr[B_SEM] & c_attr[B_MAP + int'(cfg_cid)] &
                     (~busy_q[cfg_slot] | (holder_q[cfg_slot] == cfg_cid));

  always_comb begin
    new_attr = c_attr;
    if (!c_attr[B_LOCK]) begin
      if (is_owner) new_attr = cfg_wdata[AW-1:0];
      else if (c_access) begin
        if (cfg_sec)  new_attr[B_SEC]  = cfg_wdata[B_SEC];
        if (cfg_priv) new_attr[B_PRIV] = cfg_wdata[B_PRIV];
      end
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = DW'(c_attr);
      2'd1:    cfg_rdata = DW'({busy_q[cfg_slot], sem_grant});
      2'd2:    cfg_rdata = DW'(viol_q);
      default: cfg_rdata = '0;
    endcase
  end

  logic [NUM_SLOTS-1:0] v_set, v_clr;
  assign v_set = deny ? (NUM_SLOTS'(1) << acc_slot) : '0;
  assign v_clr = (wr && cfg_sel == 2'd2 && is_owner) ? cfg_wdata[NUM_SLOTS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q   <= '0;
      busy_q   <= '0;
      holder_q <= '0;
      viol_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr && cfg_sel == 2'd0) attr_q[cfg_slot] <= new_attr;
      if (rd && cfg_sel == 2'd1 && sem_grant && !busy_q[cfg_slot]) begin
        busy_q[cfg_slot]   <= 1'b1;
        holder_q[cfg_slot] <= cfg_cid;
      end
      if (wr && cfg_sel == 2'd1 && cfg_wdata == '0 && busy_q[cfg_slot] &&
          holder_q[cfg_slot] == cfg_cid)
        busy_q[cfg_slot] <= 1'b0;
      viol_q <= (viol_q & ~v_clr) | v_set;
      irq_q  <= deny;
    end
  end
endmodule

// File: rtl/slot_firewall_chk.sv
module slot_firewall_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int CID_W     = 3,
  parameter int OWNER_CID = 1,
  localparam int SW   = $clog2(NUM_SLOTS),
  localparam int NCID = 1 << CID_W,
  localparam int AW   = 5 + CID_W + NCID
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          acc_valid,
  input logic [SW-1:0]                 acc_slot,
  input logic                          acc_sec,
  input logic                          acc_priv,
  input logic [CID_W-1:0]              acc_cid,
  input logic                          acc_allow,
  input logic                          cfg_valid,
  input logic                          cfg_write,
  input logic [SW-1:0]                 cfg_slot,
  input logic [1:0]                    cfg_sel,
  input logic [CID_W-1:0]              cfg_cid,
  input logic [NUM_SLOTS-1:0][AW-1:0]  attr_q,
  input logic [NUM_SLOTS-1:0]          viol_q,
  input logic                          viol_irq
);
  localparam int B_LOCK = 4 + CID_W, B_MAP = 5 + CID_W;

  logic [AW-1:0] a;
  logic [NUM_SLOTS-1:0][AW-3:0] upper;
  assign a = attr_q[acc_slot];
  always_comb for (int i = 0; i < NUM_SLOTS; i++) upper[i] = attr_q[i][AW-1:2];

  // R4
  sec_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_sec && a[0] |-> !acc_allow);
  // R4
  priv_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_priv && a[1] |-> !acc_allow);
  // R2
  cid_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && a[2] && !a[3] && a[4 +: CID_W] != acc_cid |-> !acc_allow);
  // R3
  empty_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && a[3] && a[B_MAP +: NCID] == '0 |-> !acc_allow);
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_write && cfg_sel == 2'd0 && attr_q[cfg_slot][B_LOCK] |=> $stable(attr_q));
  // R5
  owner_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_write && cfg_sel == 2'd0 && cfg_cid != CID_W'(OWNER_CID) |=> $stable(upper));
  // R9
  deny_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_allow |=> viol_irq && viol_q[$past(acc_slot)]);
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_irq |-> $past(acc_valid && !acc_allow));
endmodule

bind slot_firewall slot_firewall_chk #(.NUM_SLOTS(NUM_SLOTS), .CID_W(CID_W), .OWNER_CID(OWNER_CID)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_slot(acc_slot), .acc_sec(acc_sec),
  .acc_priv(acc_priv), .acc_cid(acc_cid), .acc_allow(acc_allow), .cfg_valid(cfg_valid),
  .cfg_write(cfg_write), .cfg_slot(cfg_slot), .cfg_sel(cfg_sel), .cfg_cid(cfg_cid),
  .attr_q(attr_q), .viol_q(viol_q), .viol_irq(viol_irq));

// File: tb/slot_firewall_bench.sv
module slot_firewall_bench;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_sec = 0, acc_priv = 0;
  logic [3:0] acc_slot = 0;
  logic [2:0] acc_cid = 0;
  logic acc_allow;
  logic cfg_valid = 0, cfg_write = 0, cfg_sec = 0, cfg_priv = 0;
  logic [3:0] cfg_slot = 0;
  logic [1:0] cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic [2:0] cfg_cid = 0;
  logic [15:0] cfg_rdata;
  logic viol_irq;
  int checks = 0, fails = 0;
  logic [15:0] ev = 0;
  logic [15:0] v;

  slot_firewall u_slot_firewall (.*);

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int slot, input int sel, input logic [15:0] d,
                        input int cid, input logic s, input logic p);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 1; cfg_slot = 4'(slot); cfg_sel = 2'(sel);
    cfg_wdata = d; cfg_cid = 3'(cid); cfg_sec = s; cfg_priv = p;
    @(posedge clk); #1 cfg_valid = 0;
  endtask

  task automatic cfg_rd(input int slot, input int sel, input int cid,
                        input logic s, input logic p, output logic [15:0] d);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 0; cfg_slot = 4'(slot); cfg_sel = 2'(sel);
    cfg_cid = 3'(cid); cfg_sec = s; cfg_priv = p;
    #1 d = cfg_rdata;
    @(posedge clk); #1 cfg_valid = 0;
  endtask

  task automatic acc(input string tag, input int slot, input logic s, input logic p,
                     input int cid, input logic exp);
    @(negedge clk);
    acc_valid = 1; acc_slot = 4'(slot); acc_sec = s; acc_priv = p; acc_cid = 3'(cid);
    #1 check({tag, " allow"}, acc_allow, exp);
    @(posedge clk); #1;
    check({tag, " irq"}, viol_irq, !exp);
    acc_valid = 0;
    if (!exp) ev[slot] = 1'b1;
  endtask

  task automatic t_reset;
    cfg_rd(0, 0, 6, 0, 0, v); check("R1 attr zero", v, 0);
    cfg_rd(0, 2, 6, 0, 0, v); check("R1 viol zero", v, 0);
    check("R1 irq low", viol_irq, 0);
    acc("R1 open ns", 0, 0, 0, 0, 1);
    acc("R1 open cid7", 15, 1, 1, 7, 1);
  endtask

  task automatic t_static;
    cfg_wr(3, 0, 16'h0054, 1, 1, 1);
    acc("R2 match", 3, 0, 0, 5, 1);
    acc("R2 mismatch", 3, 0, 0, 2, 0);
    cfg_rd(3, 2, 0, 0, 0, v); check("R9 sticky slot3", v, ev);
  endtask

  task automatic t_secpriv;
    cfg_wr(4, 0, 16'h0003, 1, 1, 1);
    acc("R4 nonsecure", 4, 0, 1, 0, 0);
    acc("R4 unpriv", 4, 1, 0, 0, 0);
    acc("R4 sec priv", 4, 1, 1, 0, 1);
  endtask

  task automatic t_owner;
    cfg_wr(5, 0, 16'h0054, 1, 1, 1);
    cfg_rd(5, 0, 1, 1, 1, v); check("R5 owner write", v, 16'h0054);
    cfg_wr(5, 0, 16'hFFFF, 2, 0, 0);
    cfg_rd(5, 0, 6, 0, 0, v); check("R5 foreign write ignored, foreign read", v, 16'h0054);
  endtask

  task automatic t_deleg;
    cfg_wr(6, 0, 16'h0045, 1, 1, 1);
    cfg_wr(6, 0, 16'h0072, 4, 1, 1);
    cfg_rd(6, 0, 0, 0, 0, v); check("R7 sec/priv changed only", v, 16'h0046);
    cfg_wr(6, 0, 16'h0000, 3, 1, 1);
    cfg_rd(6, 0, 0, 0, 0, v); check("R7 no-access requester ignored", v, 16'h0046);
    cfg_wr(6, 0, 16'h0001, 4, 0, 1);
    cfg_rd(6, 0, 0, 0, 0, v); check("R7 nonsecure keeps sec", v, 16'h0044);
  endtask

  task automatic t_sem;
    cfg_wr(7, 0, 16'h2408, 1, 1, 1);
    acc("R3 before take", 7, 0, 0, 2, 0);
    cfg_rd(7, 1, 6, 0, 0, v); check("R8 not in map", v, 16'h0);
    cfg_rd(7, 1, 2, 0, 0, v); check("R8 take", v, 16'h1);
    acc("R3 holder", 7, 0, 0, 2, 1);
    acc("R3 other in map", 7, 0, 0, 5, 0);
    cfg_rd(7, 1, 5, 0, 0, v); check("R8 busy refuse", v, 16'h2);
    cfg_wr(7, 1, 16'h0, 5, 0, 0);
    acc("R8 non-holder release ignored", 7, 0, 0, 2, 1);
    cfg_wr(7, 1, 16'h0, 2, 0, 0);
    cfg_rd(7, 1, 5, 0, 0, v); check("R8 take after release", v, 16'h1);
    acc("R3 new holder", 7, 0, 0, 5, 1);
    acc("R3 old holder", 7, 0, 0, 2, 0);
    cfg_wr(8, 0, 16'h0008, 1, 1, 1);
    cfg_rd(8, 1, 1, 1, 1, v); check("R3 empty map take", v, 16'h0);
    acc("R3 empty map deny", 8, 1, 1, 1, 0);
  endtask

  task automatic t_lock;
    cfg_wr(9, 0, 16'h0094, 1, 1, 1);
    cfg_wr(9, 0, 16'h0000, 1, 1, 1);
    cfg_rd(9, 0, 0, 0, 0, v); check("R6 owner write ignored", v, 16'h0094);
    cfg_wr(9, 0, 16'h0003, 1, 0, 1);
    cfg_wr(9, 0, 16'h0003, 7, 1, 1);
    cfg_rd(9, 0, 0, 0, 0, v); check("R6 delegated write ignored", v, 16'h0094);
    acc("R6 locked filter cid1", 9, 0, 0, 1, 1);
    acc("R6 locked filter cid2", 9, 0, 0, 2, 0);
  endtask

  task automatic t_w1c;
    cfg_rd(0, 2, 3, 0, 0, v); check("R9 sticky map", v, ev);
    cfg_wr(0, 2, 16'hFFFF, 2, 1, 1);
    cfg_rd(0, 2, 3, 0, 0, v); check("R10 foreign clear ignored", v, ev);
    cfg_wr(0, 2, 16'h0008, 1, 1, 1);
    ev[3] = 1'b0;
    cfg_rd(0, 2, 3, 0, 0, v); check("R10 owner clears selected", v, ev);
    check("R9 irq idle", viol_irq, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0h expected %0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_static;
    t_secpriv;
    t_owner;
    t_deleg;
    t_sem;
    t_lock;
    t_w1c;
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule